// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits on a byte-wide receive stream and decides, frame by frame, whether a received Ethernet frame should be kept or thrown away. Each byte arrives with a valid strobe. The first byte of a frame carries a start marker and the last byte carries an end marker. While the frame streams in, the block captures the destination address and counts the frame length. It compares the captured address against a programmed station address, a bank of extra exact-match address slots and the all-ones broadcast address.

One cycle after the end-marker byte, the block presents a one-cycle verdict: keep or drop, plus a miss flag for the receive descriptor. The verdict is shaped by five configuration inputs:
- promiscuous mode;
- broadcast reject;
- exact-match slot enable;
- short-frame acceptance;
- a flag saying the frame came over a FIFO-type packet interface.

CRC checking, protocol parsing, descriptors and DMA belong to neighbouring blocks.

Top module: `rx_accept_filter`

## Requirements
- R1: The destination address is the first six bytes after the start marker, the first byte being bits 47:40. A frame of 64 bytes or more whose address equals `station_addr` is kept with the miss flag low.
- R2: With `cfg_xmatch_en` high, an address equal to slot k of `alias_addr` (bits 48k+47:48k) whose `alias_valid[k]` is high counts as a station match. A slot whose valid bit is low never matches, and no slot matches while `cfg_xmatch_en` is low.
- R3: With promiscuous mode off, a frame of 64 bytes or more whose address matches nothing is dropped.
- R4: In promiscuous mode, a frame of 64 bytes or more whose address matches nothing is kept with the miss flag high.
- R5: With broadcast reject off, a broadcast frame (address 48'hFFFF_FFFF_FFFF) of 64 bytes or more is kept with the miss flag low.
- R6: With broadcast reject on and promiscuous mode off, a broadcast frame is dropped.
- R7: With broadcast reject and promiscuous mode both on, a broadcast frame of 64 bytes or more is kept with the miss flag high.
- R8: A frame of 16 bytes or fewer is dropped, whatever the configuration.
- R9: With short-frame mode off and the FIFO flag low, a frame of 17 to 63 bytes is dropped.
- R10: With short-frame mode on and the FIFO flag low, a frame of 17 to 63 bytes is kept (miss low) only on a station, slot or non-rejected broadcast match. Promiscuous mode does not rescue it.
- R11: With the FIFO flag high, a frame of 17 to 63 bytes skips the short-frame rule and is judged by the address rules that apply to a frame of 64 bytes or more.
- R12: The frame length counts from the start-marker byte to the end-marker byte inclusive. `verdict_valid` is high for exactly the one cycle after the end-marker byte is taken. `verdict_accept` and `verdict_miss` are low whenever `verdict_valid` is low, and the miss flag is high only together with accept.
- R13: During and straight after reset, all three verdict outputs are low.
- R14: A start marker arriving inside an unfinished frame restarts the length count and the address capture from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_bcast_rej | input | 1 | Broadcast reject |
| cfg_xmatch_en | input | 1 | Enable the extra exact-match slots |
| cfg_short_ok | input | 1 | Accept frames of 17 to 63 bytes |
| cfg_fifo_if | input | 1 | Frame arrives over a FIFO-type interface |
| station_addr | input | 48 | Station address |
| alias_addr | input | 720 | 15 packed 48-bit exact-match slots |
| alias_valid | input | 15 | Per-slot valid bits |
| verdict_valid | output | 1 | Verdict strobe, one cycle after the end marker |
| verdict_accept | output | 1 | Keep the frame |
| verdict_miss | output | 1 | Descriptor miss flag |

## Verification
The verdict is the only result, and it appears in the single cycle that follows the clock edge that takes the end-marker byte: one register stage, with no pipelining on the address compare. The bench drives every byte on a falling edge and reads the verdict on the first falling edge after the end-marker byte is taken, which is exactly that cycle. It then reads the outputs again one falling edge later to confirm that the strobe and both flags have returned to low. Idle cycles are inserted at random inside frames, so the verdict timing is checked against the end marker and not against a fixed byte count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned DA_BYTES = MAC_W / 8;

  typedef logic [MAC_W-1:0] mac_t;

  typedef struct packed {
    logic keep;
    logic miss;
  } rxf_verdict_t;
endpackage

// File: rtl/rxf_frame_track.sv
// Follows frame boundaries, counts bytes (saturating) and captures the
// destination address, most significant byte first.
module rxf_frame_track
  import rxf_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned LEN_W   = $clog2(MIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  output mac_t             da_o,
  output logic [LEN_W-1:0] len_o,
  output logic             eop_fire_o
);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] DA_LEN  = LEN_W'(DA_BYTES);

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] cnt_q, cnt_cur;
  mac_t             da_q, da_d;
  logic             byte_ok, da_take;

  always_comb begin
    byte_ok = in_valid && (in_sop || in_frame_q);
    if (in_sop)
      cnt_cur = LEN_W'(1);
    else if (cnt_q == LEN_SAT)
      cnt_cur = cnt_q;
    else
      cnt_cur = cnt_q + LEN_W'(1);
    da_take    = byte_ok && (in_sop || (cnt_q < DA_LEN));
    da_d       = in_sop ? {{(MAC_W-8){1'b0}}, in_data} : {da_q[MAC_W-9:0], in_data};
    in_frame_d = !in_eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      da_q       <= '0;
    end else begin
      if (byte_ok) begin
        in_frame_q <= in_frame_d;
        cnt_q      <= cnt_cur;
      end
      if (da_take)
        da_q <= da_d;
    end
  end

  assign da_o       = da_q;
  assign len_o      = cnt_cur;
  assign eop_fire_o = byte_ok && in_eop;
endmodule

// File: rtl/rxf_addr_match.sv
// Parallel comparison of the captured address against station, slots, broadcast.
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int unsigned N_SLOTS = 15
) (
  input  mac_t                     da,
  input  mac_t                     station,
  input  logic [N_SLOTS*MAC_W-1:0] slot_addr,
  input  logic [N_SLOTS-1:0]       slot_valid,
  input  logic                     slots_en,
  output logic                     stn_hit,
  output logic                     slot_hit,
  output logic                     bcast_hit
);
  logic [N_SLOTS-1:0] per_slot;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign per_slot[k] = slot_valid[k] && (slot_addr[k*MAC_W +: MAC_W] == da);
  end

  assign stn_hit   = (da == station);
  assign slot_hit  = slots_en && (|per_slot);
  assign bcast_hit = &da;
endmodule

// File: rtl/rxf_decide.sv
// Combines length class, address hits and configuration into a registered verdict.
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int unsigned SHORT_FLOOR = 16,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned LEN_W       = $clog2(MIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eop_fire,
  input  logic [LEN_W-1:0] len,
  input  logic             stn_hit,
  input  logic             slot_hit,
  input  logic             bcast_hit,
  input  logic             cfg_promisc,
  input  logic             cfg_bcast_rej,
  input  logic             cfg_short_ok,
  input  logic             cfg_fifo_if,
  output logic             v_valid,
  output logic             v_keep,
  output logic             v_miss
);
  localparam logic [LEN_W-1:0] FLOOR_L = LEN_W'(SHORT_FLOOR);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);

  rxf_verdict_t vd_d, vd_q;
  logic         valid_q;
  logic         too_small, is_short, addr_ok;

  always_comb begin
    too_small = (len <= FLOOR_L);
    is_short  = (len < MIN_L);
    addr_ok   = stn_hit || slot_hit || (bcast_hit && !cfg_bcast_rej);
    vd_d      = '0;
    if (eop_fire) begin
      if (too_small) begin
        vd_d = '0;
      end else if (is_short && !cfg_fifo_if) begin
        vd_d.keep = cfg_short_ok && addr_ok;
      end else if (addr_ok) begin
        vd_d.keep = 1'b1;
      end else if (cfg_promisc) begin
        vd_d.keep = 1'b1;
        vd_d.miss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vd_q    <= '0;
    end else begin
      valid_q <= eop_fire;
      vd_q    <= vd_d;
    end
  end

  assign v_valid = valid_q;
  assign v_keep  = vd_q.keep;
  assign v_miss  = vd_q.miss;
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int unsigned N_ALIAS     = 15,
  parameter int unsigned SHORT_FLOOR = 16,
  parameter int unsigned MIN_LEN     = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sop,
  input  logic                       in_eop,
  input  logic [7:0]                 in_data,
  input  logic                       cfg_promisc,
  input  logic                       cfg_bcast_rej,
  input  logic                       cfg_xmatch_en,
  input  logic                       cfg_short_ok,
  input  logic                       cfg_fifo_if,
  input  logic [47:0]                station_addr,
  input  logic [N_ALIAS*48-1:0]      alias_addr,
  input  logic [N_ALIAS-1:0]         alias_valid,
  output logic                       verdict_valid,
  output logic                       verdict_accept,
  output logic                       verdict_miss
);
  localparam int unsigned LEN_W = $clog2(MIN_LEN + 1);

  mac_t             frame_da;
  logic [LEN_W-1:0] frame_len;
  logic             eop_fire;
  logic             stn_hit, slot_hit, bcast_hit;

  rxf_frame_track #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .da_o      (frame_da),
    .len_o     (frame_len),
    .eop_fire_o(eop_fire)
  );

  rxf_addr_match #(.N_SLOTS(N_ALIAS)) u_match (
    .da        (frame_da),
    .station   (station_addr),
    .slot_addr (alias_addr),
    .slot_valid(alias_valid),
    .slots_en  (cfg_xmatch_en),
    .stn_hit   (stn_hit),
    .slot_hit  (slot_hit),
    .bcast_hit (bcast_hit)
  );

  rxf_decide #(.SHORT_FLOOR(SHORT_FLOOR), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .eop_fire     (eop_fire),
    .len          (frame_len),
    .stn_hit      (stn_hit),
    .slot_hit     (slot_hit),
    .bcast_hit    (bcast_hit),
    .cfg_promisc  (cfg_promisc),
    .cfg_bcast_rej(cfg_bcast_rej),
    .cfg_short_ok (cfg_short_ok),
    .cfg_fifo_if  (cfg_fifo_if),
    .v_valid      (verdict_valid),
    .v_keep       (verdict_accept),
    .v_miss       (verdict_miss)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_eop,
  input logic        cfg_promisc,
  input logic        cfg_bcast_rej,
  input logic        cfg_xmatch_en,
  input logic [47:0] station_addr,
  input logic [47:0] frame_da,
  input logic        verdict_valid,
  input logic        verdict_accept,
  input logic        verdict_miss
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (!verdict_accept && !verdict_miss));

  // R12
  miss_with_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_miss |-> verdict_accept);

  // R12
  verdict_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(in_valid && in_eop));

  // R6
  bcast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && $past(cfg_bcast_rej && !cfg_promisc && !cfg_xmatch_en &&
                            (&frame_da) && !(&station_addr)))
    |-> !verdict_accept);

  // R4
  miss_needs_promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_miss |-> $past(cfg_promisc));
endmodule

bind rx_accept_filter rxf_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_eop        (in_eop),
  .cfg_promisc   (cfg_promisc),
  .cfg_bcast_rej (cfg_bcast_rej),
  .cfg_xmatch_en (cfg_xmatch_en),
  .station_addr  (station_addr),
  .frame_da      (frame_da),
  .verdict_valid (verdict_valid),
  .verdict_accept(verdict_accept),
  .verdict_miss  (verdict_miss)
);

// File: tb/rx_accept_filter_test.sv
`timescale 1ns/1ps
module rx_accept_filter_test;
  localparam int NS = 15;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STN = 48'h0211_2233_4455;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic cfg_promisc, cfg_bcast_rej, cfg_xmatch_en, cfg_short_ok, cfg_fifo_if;
  logic [47:0] station_addr;
  logic [NS*48-1:0] alias_addr;
  logic [NS-1:0] alias_valid;
  logic verdict_valid, verdict_accept, verdict_miss;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rx_accept_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_promisc(cfg_promisc), .cfg_bcast_rej(cfg_bcast_rej),
    .cfg_xmatch_en(cfg_xmatch_en), .cfg_short_ok(cfg_short_ok), .cfg_fifo_if(cfg_fifo_if),
    .station_addr(station_addr), .alias_addr(alias_addr), .alias_valid(alias_valid),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept), .verdict_miss(verdict_miss)
  );

  task automatic chk(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual valid/accept/miss=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic void model(input logic [47:0] da, input int len,
                                output logic acc, output logic miss, output string req);
    logic hit, bc, ok;
    hit = (da == station_addr);
    for (int k = 0; k < NS; k++)
      if (cfg_xmatch_en && alias_valid[k] && alias_addr[k*48 +: 48] == da) hit = 1'b1;
    bc = (da == BC);
    ok = hit || (bc && !cfg_bcast_rej);
    acc = 1'b0; miss = 1'b0;
    if (len <= 16) req = "R8";
    else if (len < 64 && !cfg_fifo_if) begin
      if (!cfg_short_ok) req = "R9";
      else begin acc = ok; req = "R10"; end
    end else begin
      req = (len < 64) ? "R11" : "R1";
      if (ok) acc = 1'b1;
      else if (cfg_promisc) begin acc = 1'b1; miss = 1'b1; req = bc ? "R7" : "R4"; end
      else req = bc ? "R6" : "R3";
    end
  endfunction

  task automatic send(input logic [47:0] da, input int len, input bit gaps, input bit with_eop);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = with_eop && (i == len - 1);
      in_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic frame_chk(input logic [47:0] da, input int len, input bit gaps,
                           input logic ea, input logic em, input string req);
    logic [2:0] got;
    send(da, len, gaps, 1'b1);
    got = {verdict_valid, verdict_accept, verdict_miss};
    chk(got == {1'b1, ea, em}, req, got, {1'b1, ea, em});
    @(negedge clk);
    got = {verdict_valid, verdict_accept, verdict_miss};
    chk(got == 3'b000, "R12", got, 3'b000);
  endtask

  task automatic cfg(input bit p, input bit b, input bit x, input bit s, input bit f);
    cfg_promisc = p; cfg_bcast_rej = b; cfg_xmatch_en = x; cfg_short_ok = s; cfg_fifo_if = f;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] rnd;
    logic ea, em;
    string rq;
    process::self().srandom(32'h5eed_1234);
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    cfg(0, 0, 0, 0, 0);
    station_addr = STN;
    for (int k = 0; k < NS; k++) alias_addr[k*48 +: 48] = {16'h0A00, 32'($urandom)} + 48'(k);
    alias_valid = '0;
    repeat (3) @(negedge clk);
    chk({verdict_valid, verdict_accept, verdict_miss} == 3'b000, "R13",
        {verdict_valid, verdict_accept, verdict_miss}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({verdict_valid, verdict_accept, verdict_miss} == 3'b000, "R13",
        {verdict_valid, verdict_accept, verdict_miss}, 3'b000);

    rnd = 48'h0CDE_F012_3456;
    frame_chk(STN, 64, 0, 1, 0, "R1 station 64B");
    frame_chk(STN, 100, 1, 1, 0, "R1 station gaps");
    frame_chk(rnd, 80, 0, 0, 0, "R3 no match");
    cfg(1, 0, 0, 0, 0);
    frame_chk(rnd, 80, 0, 1, 1, "R4 promisc");
    cfg(0, 0, 0, 0, 0);
    frame_chk(BC, 64, 0, 1, 0, "R5 broadcast");
    cfg(0, 1, 0, 0, 0);
    frame_chk(BC, 64, 0, 0, 0, "R6 bcast reject");
    cfg(1, 1, 0, 0, 0);
    frame_chk(BC, 70, 0, 1, 1, "R7 reject+promisc");
    cfg(0, 0, 1, 0, 0);
    alias_valid[3] = 1'b1;
    frame_chk(alias_addr[3*48 +: 48], 64, 0, 1, 0, "R2 slot hit");
    frame_chk(alias_addr[5*48 +: 48], 64, 0, 0, 0, "R2 invalid slot");
    cfg(0, 0, 0, 0, 0);
    frame_chk(alias_addr[3*48 +: 48], 64, 0, 0, 0, "R2 slots disabled");
    frame_chk(STN, 63, 0, 0, 0, "R9 63B");
    cfg(1, 0, 0, 1, 0);
    frame_chk(STN, 16, 0, 0, 0, "R8 16B");
    frame_chk(STN, 17, 0, 1, 0, "R10 17B station");
    frame_chk(rnd, 40, 0, 0, 0, "R10 promisc no rescue");
    cfg(0, 0, 0, 0, 1);
    frame_chk(STN, 30, 0, 1, 0, "R11 fifo short");
    frame_chk(STN, 16, 0, 0, 0, "R8 fifo 16B");
    cfg(0, 0, 0, 0, 0);
    send(rnd, 60, 0, 1'b0);
    frame_chk(STN, 20, 0, 0, 0, "R14 restart");

    for (int n = 0; n < 400; n++) begin
      logic [47:0] da;
      int len;
      if (n % 50 == 0) alias_valid = NS'($urandom);
      cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
      case ($urandom % 4)
        0: da = STN;
        1: da = alias_addr[($urandom % NS)*48 +: 48];
        2: da = BC;
        default: da = {16'h0C00, 32'($urandom)};
      endcase
      case ($urandom % 4)
        0: len = 1 + $urandom % 20;
        1: len = 58 + $urandom % 10;
        2: len = 64 + $urandom % 40;
        default: len = 17 + $urandom % 47;
      endcase
      model(da, len, ea, em, rq);
      frame_chk(da, len, 1, ea, em, rq);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule